// File: doc/BRIEF.md
# External Interrupt Line Conditioner

The block watches three asynchronous interrupt pins and turns each into a request that a parent interrupt controller can accept. The parent only takes active-high levels or rising edges, so the block inverts pins that are configured active-low or falling-edge before it detects anything. Each pin passes through a two-flop synchronizer. It is then sampled on a per-line tick, which is either every clock (fast) or one clock in every `SLOW_DIV` (slow).

Each line has an 8-bit control byte holding a trigger type, an enable, a sampling-speed select and a pending flag. In the edge modes, a detected edge sets a sticky pending flag, and software clears it by writing a one. In the level modes, the pending bit simply reflects the converted level. The request toward the parent is the pending bit ANDed with the enable bit.

A parameter chooses how the control bytes are laid out. In the shared layout, all three bytes sit in one 32-bit word with line 0 in the high byte. In the split layout, each line has its own word at a fixed offset.

Top module: `ext_irq_conditioner`

## Requirements
- R1: After reset every control byte reads zero (active-high level, disabled, slow sampling, not pending) and all requests are low.
- R2: Within a control byte, bits 7:6 hold the trigger type, bit 5 the enable, bit 4 the fast-sampling select and bit 0 the pending flag. Bits 3:1 always read zero, and so do the word bits not owned by any line.
- R3: With `SHARED_WORD`=1, line i uses bits [(2-i)*8+7:(2-i)*8] of the word at address 0x000, so line 0 is in bits 23:16 and line 2 is in bits 7:0. Bits 31:24 are ignored on write.
- R4: With `SHARED_WORD`=0, lines 0, 1 and 2 use bits 7:0 of the words at 0x000, 0x328 and 0x32C. Any other address reads zero and ignores writes.
- R5: Trigger type 00 (active-high level): the request equals enable AND the synchronized pin, and the pending bit reads that level without holding it.
- R6: Trigger type 01 (active-low level): the request equals enable AND NOT the synchronized pin.
- R7: Trigger type 10 (rising edge): a rising pin edge sets the pending flag. The flag holds after the pin returns low, and the request equals pending AND enable.
- R8: Trigger type 11 (falling edge): a falling pin edge sets the pending flag and a rising edge does not.
- R9: Writing 1 to a line's bit 0 clears its pending flag. Writing 0 to bit 0 leaves the flag unchanged.
- R10: With enable at 0, a line's request stays low while its edges are still captured in the pending flag. Each line's enable is independent of the others.
- R11: With bit 4 set, a pin change reaches the request on the third rising clock edge after it, and not on the second. With bit 4 clear, it reaches the request within 2+`SLOW_DIV` clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Byte address for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| pinIn | input | 3 | Asynchronous external interrupt pins |
| irqReq | output | 3 | Requests to the parent, active-high |

## Verification
A wrong synchronizer depth or a mis-gated tick shows up as a request that rises one cycle too early or too late relative to a pin change. The directed tests pin that down with checks at the second and third clock edges. A pending flag that fails to hold, or that clears on a zero write, shows as a request dropping on the next edge after the pin returns or after the write. A mis-packed control byte shows immediately in the read word. An inversion applied on the wrong side of the sample register shows as a request appearing right after a mode change, with no pin activity at all.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int LINES  = 3;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 32;

  localparam int POS_PEND = 0;
  localparam int POS_CLK  = 4;
  localparam int POS_EN   = 5;
  localparam int POS_TRIG = 6;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef struct packed {
    trig_e trig;
    logic  en;
    logic  fastClk;
  } lineCfg_t;

  typedef struct packed {
    logic [LINES-1:0] pendClr;
  } ctlStrobe_t;

  // Split layout: each line at its own word.
  function automatic logic [11:0] lineOffset(int idx);
    case (idx)
      0:       return 12'h000;
      1:       return 12'h328;
      default: return 12'h32C;
    endcase
  endfunction

  // Shared layout: line 0 sits in the highest used byte.
  function automatic int sharedBase(int idx);
    return (LINES - 1 - idx) * BYTE_W;
  endfunction

  function automatic logic [BYTE_W-1:0] packByte(lineCfg_t c, logic pend);
    return {c.trig, c.en, c.fastClk, 3'b000, pend};
  endfunction
endpackage

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter bit SHARED_WORD = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [REG_W-1:0]       wrData,
  input  logic [LINES-1:0]       pendRd,
  output lineCfg_t [LINES-1:0]   cfg,
  output ctlStrobe_t             strobe,
  output logic [REG_W-1:0]       rdData
);
  logic [LINES-1:0]              hit;
  logic [LINES-1:0][BYTE_W-1:0]  wrByte;
  logic [LINES-1:0][BYTE_W-1:0]  rdByte;
  logic                          unusedWr;

  assign unusedWr = ^{wrData, wrByte};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (SHARED_WORD) begin : g_shared
      localparam int Base = sharedBase(i);
      assign hit[i]    = (addr == '0);
      assign wrByte[i] = wrData[Base +: BYTE_W];
    end else begin : g_split
      assign hit[i]    = (addr == ADDR_W'(lineOffset(i)));
      assign wrByte[i] = wrData[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (wrEn && hit[i]) begin
          cfg[i].trig    <= trig_e'(wrByte[i][POS_TRIG +: 2]);
          cfg[i].en      <= wrByte[i][POS_EN];
          cfg[i].fastClk <= wrByte[i][POS_CLK];
        end
      end
    end
  end

  always_comb begin
    strobe = '0;
    for (int i = 0; i < LINES; i++) begin
      strobe.pendClr[i] = wrEn & hit[i] & wrByte[i][POS_PEND];
      rdByte[i]         = packByte(cfg[i], pendRd[i]);
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit[i]) rdData[(SHARED_WORD ? sharedBase(i) : 0) +: BYTE_W] = rdByte[i];
    end
  end
endmodule

// File: rtl/eirq_datapath.sv
module eirq_datapath
  import eirq_pkg::*;
#(
  parameter int SLOW_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LINES-1:0]     pinIn,
  input  lineCfg_t [LINES-1:0] cfg,
  input  ctlStrobe_t           strobe,
  output logic [LINES-1:0]     pendRd,
  output logic [LINES-1:0]     irqReq,
  output logic [LINES-1:0]     pendQ,
  output logic [LINES-1:0]     edgeHit,
  output logic [LINES-1:0]     edgeMode
);
  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [CNT_W-1:0]        divCnt;
  logic                    slowTick;
  logic [LINES-1:0][1:0]   syncQ;
  logic [LINES-1:0]        sampQ;
  logic [LINES-1:0]        inv;
  logic [LINES-1:0]        tick;
  logic [LINES-1:0]        levelNow;

  assign slowTick = (divCnt == CNT_W'(SLOW_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         divCnt <= '0;
    else if (slowTick) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      inv[i]      = cfg[i].trig[0];
      edgeMode[i] = cfg[i].trig[1];
      tick[i]     = cfg[i].fastClk | slowTick;
      edgeHit[i]  = tick[i] & edgeMode[i]
                  & (syncQ[i][1] ^ inv[i]) & ~(sampQ[i] ^ inv[i]);
      levelNow[i] = sampQ[i] ^ inv[i];
      pendRd[i]   = edgeMode[i] ? pendQ[i] : levelNow[i];
      irqReq[i]   = cfg[i].en & pendRd[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      sampQ <= '0;
      pendQ <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        syncQ[i] <= {syncQ[i][0], pinIn[i]};
        if (tick[i]) sampQ[i] <= syncQ[i][1];
        if (!edgeMode[i])              pendQ[i] <= 1'b0;
        else if (edgeHit[i])           pendQ[i] <= 1'b1;
        else if (strobe.pendClr[i])    pendQ[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner
  import eirq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter bit SHARED_WORD = 1'b1,
  parameter int SLOW_DIV    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  irqReq
);
  lineCfg_t [LINES-1:0] cfg;
  ctlStrobe_t           strobe;
  logic [LINES-1:0]     pendRd;
  logic [LINES-1:0]     pendQ;
  logic [LINES-1:0]     edgeHit;
  logic [LINES-1:0]     edgeMode;
  logic [LINES-1:0]     enVec;

  always_comb for (int i = 0; i < LINES; i++) enVec[i] = cfg[i].en;

  eirq_ctrl #(.ADDR_W(ADDR_W), .SHARED_WORD(SHARED_WORD)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr),
    .wrData(regWrData), .pendRd(pendRd), .cfg(cfg), .strobe(strobe),
    .rdData(regRdData)
  );

  eirq_datapath #(.SLOW_DIV(SLOW_DIV)) dpath (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cfg(cfg), .strobe(strobe),
    .pendRd(pendRd), .irqReq(irqReq), .pendQ(pendQ), .edgeHit(edgeHit),
    .edgeMode(edgeMode)
  );
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk
  import eirq_pkg::*;
#(
  parameter bit SHARED_WORD = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic [LINES-1:0] irqReq,
  input logic [LINES-1:0] enVec,
  input logic [LINES-1:0] pendQ,
  input logic [LINES-1:0] edgeHit,
  input logic [LINES-1:0] edgeMode,
  input logic [LINES-1:0] pendClr,
  input logic [REG_W-1:0] regRdData
);
  localparam logic [REG_W-1:0] RsvdMask = SHARED_WORD ? 32'hFF0E_0E0E : 32'hFFFF_FF0E;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & RsvdMask) == '0); // R2

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & ~enVec) == '0); // R10

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
      edgeHit[i] |=> pendQ[i]); // R7

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      edgeMode[i] && pendQ[i] && !pendClr[i] |=> pendQ[i] || !edgeMode[i]); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      edgeMode[i] && pendClr[i] && !edgeHit[i] |=> !pendQ[i]); // R9

    AST_LEVEL_NOT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      !edgeMode[i] |=> !pendQ[i]); // R5
  end
endmodule

bind ext_irq_conditioner eirq_chk #(.SHARED_WORD(SHARED_WORD)) chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .enVec(enVec), .pendQ(pendQ),
  .edgeHit(edgeHit), .edgeMode(edgeMode), .pendClr(strobe.pendClr),
  .regRdData(regRdData)
);

// File: tb/ext_irq_conditioner_test.sv
module ext_irq_conditioner_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_DIV   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEnA = 1'b0, wrEnB = 1'b0;
  logic [11:0] addrA = '0, addrB = '0;
  logic [31:0] wdA = '0, wdB = '0;
  logic [31:0] rdA, rdB;
  logic [2:0]  pinA = '0, pinB = '0;
  logic [2:0]  reqA, reqB;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_conditioner #(.ADDR_W(12), .SHARED_WORD(1'b1), .SLOW_DIV(SLOW_DIV)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(wrEnA), .regAddr(addrA), .regWrData(wdA),
    .regRdData(rdA), .pinIn(pinA), .irqReq(reqA));

  ext_irq_conditioner #(.ADDR_W(12), .SHARED_WORD(1'b0), .SLOW_DIV(SLOW_DIV)) uutSep (
    .clk(clk), .rstN(rstN), .regWrEn(wrEnB), .regAddr(addrB), .regWrData(wdB),
    .regRdData(rdB), .pinIn(pinB), .irqReq(reqB));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeA(logic [31:0] d);
    addrA = '0; wdA = d; wrEnA = 1'b1;
    @(negedge clk);
    wrEnA = 1'b0;
  endtask

  task automatic readA(output logic [31:0] d);
    addrA = '0; #1; d = rdA;
  endtask

  task automatic writeB(logic [11:0] a, logic [31:0] d);
    addrB = a; wdB = d; wrEnB = 1'b1;
    @(negedge clk);
    wrEnB = 1'b0;
  endtask

  task automatic readB(logic [11:0] a, output logic [31:0] d);
    addrB = a; #1; d = rdB;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    readA(d);
    check("R1 shared word after reset", d, 32'h0);
    check("R1 requests after reset", {29'h0, reqA}, 32'h0);
    readB(12'h328, d);
    check("R1 split word after reset", d, 32'h0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    // line0 0xFF (fall,en,fast,junk), line1 0x60 (low,en), line2 0x90 (rise,fast)
    writeA(32'hAAFF_6090);
    readA(d);
    check("R2 R3 field packing", d, 32'h00F0_6190);
    check("R6 active-low with pin low", {29'h0, reqA}, 32'h2);
    writeA(32'h0);
  endtask

  task automatic t_levelHigh();
    logic [31:0] d;
    writeA(32'h0030_3030);
    pinA = 3'b101;
    waitCyc(2);
    check("R11 fast latency not at 2", {29'h0, reqA}, 32'h0);
    waitCyc(1);
    check("R5 high level request", {29'h0, reqA}, 32'h5);
    readA(d);
    check("R5 level shows in pending bit", d, 32'h0031_3031);
    pinA = 3'b000;
    waitCyc(3);
    check("R5 level not held", {29'h0, reqA}, 32'h0);
  endtask

  task automatic t_levelLow();
    writeA(32'h0070_7070);
    check("R6 low level idle pins", {29'h0, reqA}, 32'h7);
    pinA = 3'b010;
    waitCyc(3);
    check("R6 low level one pin high", {29'h0, reqA}, 32'h5);
    pinA = 3'b000;
    writeA(32'h0);
    waitCyc(3);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    writeA(32'h00B0_B0B0);
    pinA = 3'b100;
    waitCyc(3);
    check("R7 rising edge request", {29'h0, reqA}, 32'h4);
    pinA = 3'b000;
    waitCyc(4);
    check("R7 pending sticky", {29'h0, reqA}, 32'h4);
    readA(d);
    check("R7 pending readback", d, 32'h00B0_B0B1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    writeA(32'h00B0_B0B0);
    check("R9 zero write keeps pending", {29'h0, reqA}, 32'h4);
    writeA(32'h00B0_B0B1);
    check("R9 one write clears pending", {29'h0, reqA}, 32'h0);
    readA(d);
    check("R9 readback after clear", d, 32'h00B0_B0B0);
  endtask

  task automatic t_fall();
    writeA(32'h00F0_F0F0);
    check("R8 mode change no spurious edge", {29'h0, reqA}, 32'h0);
    pinA = 3'b001;
    waitCyc(3);
    check("R8 rising ignored in fall mode", {29'h0, reqA}, 32'h0);
    pinA = 3'b000;
    waitCyc(3);
    check("R8 falling edge request", {29'h0, reqA}, 32'h1);
    writeA(32'h00F1_F0F0);
    check("R9 clear in fall mode", {29'h0, reqA}, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    writeA(32'h0090_9090);
    pinA = 3'b010;
    waitCyc(3);
    check("R10 masked line no request", {29'h0, reqA}, 32'h0);
    readA(d);
    check("R10 masked edge still pending", d, 32'h0090_9190);
    writeA(32'h0090_B090);
    check("R10 enable one line", {29'h0, reqA}, 32'h2);
    writeA(32'h0090_B190);
    check("R10 cleared after unmask", {29'h0, reqA}, 32'h0);
    pinA = 3'b000;
    waitCyc(3);
  endtask

  task automatic t_slow();
    writeA(32'h00A0_A0A0);
    pinA = 3'b001;
    waitCyc(2 + SLOW_DIV);
    check("R11 slow sampling bound", {29'h0, reqA}, 32'h1);
    writeA(32'h00A1_A0A0);
    check("R11 slow clear", {29'h0, reqA}, 32'h0);
    pinA = 3'b000;
    writeA(32'h0);
    waitCyc(SLOW_DIV + 3);
  endtask

  task automatic t_split();
    logic [31:0] d;
    writeB(12'h328, 32'hFFFF_FFB0);
    readB(12'h328, d);
    check("R4 line1 word", d, 32'h0000_00B0);
    readB(12'h000, d);
    check("R4 line0 untouched", d, 32'h0);
    readB(12'h32C, d);
    check("R4 line2 untouched", d, 32'h0);
    writeB(12'h100, 32'h0000_0030);
    readB(12'h100, d);
    check("R4 unmapped reads zero", d, 32'h0);
    readB(12'h000, d);
    check("R4 unmapped write ignored line0", d, 32'h0);
    readB(12'h32C, d);
    check("R4 unmapped write ignored line2", d, 32'h0);
    pinB = 3'b010;
    waitCyc(3);
    check("R4 split line1 edge", {29'h0, reqB}, 32'h2);
    writeB(12'h328, 32'h0000_00B1);
    check("R4 split line1 clear", {29'h0, reqB}, 32'h0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    t_reset();
    t_fields();
    t_levelHigh();
    t_levelLow();
    t_rise();
    t_w1c();
    t_fall();
    t_mask();
    t_slow();
    t_split();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule